// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block decides which of a bank of CAN message mailboxes is handed next to the bit-level protocol engine. Software configures each mailbox over a simple register write port. It loads the identifier word, the control word (length, remote flag, 6-bit priority) and two data words for a chosen mailbox. It sets the enable and direction masks. It then raises transmit requests by writing ones to the request-set register. The arbiter considers only mailboxes that are enabled, set to transmit and requesting. Among these it grants the one with the largest priority value. When two have the same priority, the higher mailbox number wins.

The engine sees a held grant (`eng_valid` with the mailbox number and the decoded frame fields) and answers with a one-cycle `eng_done` pulse. When a frame is retired, the request bit of that mailbox drops and its acknowledge bit rises. If the mailbox interrupt mask bit is set, the global mailbox interrupt flag is also raised. A grant in flight is never preempted: a new decision is taken only from the idle state.

The control is a three-state machine. **ST_IDLE** moves to **ST_BUSY** when at least one mailbox is eligible, and latches the winner. **ST_BUSY** holds the grant and moves to **ST_RETIRE** on `eng_done`. **ST_RETIRE** lasts one cycle, updates the request, acknowledge and interrupt state, and returns to **ST_IDLE**.

Top module: `can_tx_mbox_arb`

## Requirements
- R1: After reset the pending, acknowledge, enable, direction and interrupt-mask state is all zero, `irq_flag` is 0 and `eng_valid` is 0.
- R2: A mailbox is granted only if its enable bit (address 0) is 1, its direction bit (address 1, 0 = transmit, 1 = receive) is 0 and its request bit is 1. A mailbox that fails this test keeps its request bit and is granted as soon as it becomes eligible.
- R3: Among eligible mailboxes, the grant goes to the one with the largest priority value, which sits in control-word bits 13:8 (control word at address 7).
- R4: When eligible mailboxes share the largest priority, the highest-numbered one is granted.
- R5: A write to address 2 sets the request bit of every mailbox whose data bit is 1. Zero bits leave requests unchanged.
- R6: When a frame is retired, that mailbox's request bit clears and its acknowledge bit sets, both visible two clock edges after the edge that samples `eng_done`. The mailbox is not granted again without a new request.
- R7: A write to address 3 clears every acknowledge bit whose data bit is 1. Zero bits have no effect.
- R8: A retire raises `irq_flag` only if the mailbox's bit in the interrupt mask (address 4) is 1. `irq_flag` clears only on a write to address 5 with data bit 15 set.
- R9: The identifier word (address 6) marks an extended frame with bit 31. The identifier is bits 28:0 when extended, or bits 28:18 when standard. The control word gives the length code in bits 3:0 and the remote flag in bit 4. Data words at addresses 8 and 9 form the payload `{high, low}`. All of these are presented for the granted mailbox.
- R10: While `eng_valid` is high and `eng_done` has not arrived, `eng_mb` stays constant and no other request preempts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_mb | input | 5 | Mailbox index for per-mailbox words |
| cfg_wdata | input | 32 | Write data |
| pend_mask | output | 32 | Transmit request bits |
| ack_mask | output | 32 | Transmit acknowledge bits |
| irq_flag | output | 1 | Global mailbox interrupt flag |
| eng_valid | output | 1 | Grant held toward the protocol engine |
| eng_mb | output | 5 | Granted mailbox number |
| eng_ext | output | 1 | Granted frame uses an extended identifier |
| eng_can_id | output | 29 | Granted identifier, right-aligned |
| eng_rtr | output | 1 | Granted frame is a remote request |
| eng_dlc | output | 4 | Granted data length code |
| eng_payload | output | 64 | Granted data, high word first |
| eng_done | input | 1 | Engine finished the granted frame |

## Verification
A request written at one edge is seen in `pend_mask` right after that edge. The grant appears one edge later, because the decision is registered from ST_IDLE. Acknowledge, request clearing and `irq_flag` change two edges after the edge that samples `eng_done`: one edge enters ST_RETIRE and the next applies the update. The bench drives on falling edges and polls `eng_valid` on falling edges with a bound. After a done pulse it samples the retire results exactly at the second falling edge. Ignore and no-preemption cases are held for several idle cycles with checks at the ports.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int FLAG_BIT = 15;

    localparam logic [ADDR_W-1:0] A_ENABLE = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIR    = 4'd1;
    localparam logic [ADDR_W-1:0] A_REQSET = 4'd2;
    localparam logic [ADDR_W-1:0] A_ACKCLR = 4'd3;
    localparam logic [ADDR_W-1:0] A_IMASK  = 4'd4;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'd5;
    localparam logic [ADDR_W-1:0] A_ID     = 4'd6;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd7;
    localparam logic [ADDR_W-1:0] A_DLO    = 4'd8;
    localparam logic [ADDR_W-1:0] A_DHI    = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_RETIRE = 2'd2
    } arb_state_e;
endpackage

// File: rtl/can_arb_regs.sv
module can_arb_regs
    import can_arb_pkg::*;
#(
    parameter int NUM_MB = 32,
    parameter int MB_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              retire,
    input  logic [MB_W-1:0]   retire_mb,
    output logic [NUM_MB-1:0] en_q,
    output logic [NUM_MB-1:0] dir_q,
    output logic [NUM_MB-1:0] req_q,
    output logic [NUM_MB-1:0] ack_q,
    output logic [NUM_MB-1:0] imask_q,
    output logic              gmif_q
);
    logic [NUM_MB-1:0] set_vec, clr_vec, ackc_vec, req_n, ack_n;
    logic              set_wr, gmif_n;

    always_comb begin
        set_wr   = wr_en && (wr_addr == A_REQSET);
        set_vec  = set_wr ? wr_data[NUM_MB-1:0] : '0;
        clr_vec  = retire ? (NUM_MB'(1) << retire_mb) : '0;
        ackc_vec = (wr_en && (wr_addr == A_ACKCLR)) ? wr_data[NUM_MB-1:0] : '0;
        req_n    = (req_q & ~clr_vec) | set_vec;
        ack_n    = (ack_q & ~ackc_vec) | clr_vec;
        gmif_n   = (gmif_q && !(wr_en && (wr_addr == A_FLAG) && wr_data[FLAG_BIT]))
                   || (retire && imask_q[retire_mb]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            dir_q   <= '0;
            req_q   <= '0;
            ack_q   <= '0;
            imask_q <= '0;
            gmif_q  <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_ENABLE)) en_q    <= wr_data[NUM_MB-1:0];
            if (wr_en && (wr_addr == A_DIR))    dir_q   <= wr_data[NUM_MB-1:0];
            if (wr_en && (wr_addr == A_IMASK))  imask_q <= wr_data[NUM_MB-1:0];
            req_q  <= req_n;
            ack_q  <= ack_n;
            gmif_q <= gmif_n;
        end
    end

    AST_RETIRE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> ack_q[$past(retire_mb)]) else $error("ack not set on retire"); // R6
    AST_RETIRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !(set_wr && wr_data[retire_mb])) |=> !req_q[$past(retire_mb)])
        else $error("request kept after retire"); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !imask_q[retire_mb] && !gmif_q) |=> !gmif_q)
        else $error("masked retire raised flag"); // R8
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && imask_q[retire_mb]) |=> gmif_q)
        else $error("unmasked retire missed flag"); // R8
endmodule

// File: rtl/can_arb_store.sv
module can_arb_store
    import can_arb_pkg::*;
#(
    parameter int NUM_MB   = 32,
    parameter int MB_W     = 5,
    parameter int PRIO_W   = 6,
    parameter int PRIO_LSB = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [MB_W-1:0]               wr_mb,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [MB_W-1:0]               sel_mb,
    output logic [NUM_MB-1:0][PRIO_W-1:0] prio_vec,
    output logic                          sel_ext,
    output logic [28:0]                   sel_can_id,
    output logic                          sel_rtr,
    output logic [3:0]                    sel_dlc,
    output logic [2*REG_W-1:0]            sel_payload
);
    logic              ext_q  [NUM_MB];
    logic [28:0]       cid_q  [NUM_MB];
    logic              rtr_q  [NUM_MB];
    logic [3:0]        dlc_q  [NUM_MB];
    logic [PRIO_W-1:0] prio_q [NUM_MB];
    logic [REG_W-1:0]  dlo_q  [NUM_MB];
    logic [REG_W-1:0]  dhi_q  [NUM_MB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MB; i++) begin
                ext_q[i]  <= 1'b0;
                cid_q[i]  <= '0;
                rtr_q[i]  <= 1'b0;
                dlc_q[i]  <= '0;
                prio_q[i] <= '0;
                dlo_q[i]  <= '0;
                dhi_q[i]  <= '0;
            end
        end else if (wr_en) begin
            unique case (wr_addr)
                A_ID: begin
                    ext_q[wr_mb] <= wr_data[31];
                    cid_q[wr_mb] <= wr_data[31] ? wr_data[28:0] : {18'd0, wr_data[28:18]};
                end
                A_CTRL: begin
                    dlc_q[wr_mb]  <= wr_data[3:0];
                    rtr_q[wr_mb]  <= wr_data[4];
                    prio_q[wr_mb] <= wr_data[PRIO_LSB +: PRIO_W];
                end
                A_DLO:   dlo_q[wr_mb] <= wr_data;
                A_DHI:   dhi_q[wr_mb] <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_MB; g++) begin : g_prio
        assign prio_vec[g] = prio_q[g];
    end

    assign sel_ext     = ext_q[sel_mb];
    assign sel_can_id  = cid_q[sel_mb];
    assign sel_rtr     = rtr_q[sel_mb];
    assign sel_dlc     = dlc_q[sel_mb];
    assign sel_payload = {dhi_q[sel_mb], dlo_q[sel_mb]};
endmodule

// File: rtl/can_arb_pick.sv
module can_arb_pick #(
    parameter int NUM_MB = 32,
    parameter int MB_W   = 5,
    parameter int PRIO_W = 6
) (
    input  logic [NUM_MB-1:0]             cand,
    input  logic [NUM_MB-1:0][PRIO_W-1:0] prio_vec,
    output logic                          any,
    output logic [MB_W-1:0]               win
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (cand[i] && (!any || (prio_vec[i] >= best))) begin
                any  = 1'b1;
                best = prio_vec[i];
                win  = MB_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_tx_mbox_arb.sv
module can_tx_mbox_arb
    import can_arb_pkg::*;
#(
    parameter int NUM_MB   = 32,
    parameter int PRIO_W   = 6,
    parameter int PRIO_LSB = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr,
    input  logic [3:0]   cfg_addr,
    input  logic [4:0]   cfg_mb,
    input  logic [31:0]  cfg_wdata,
    output logic [31:0]  pend_mask,
    output logic [31:0]  ack_mask,
    output logic         irq_flag,
    output logic         eng_valid,
    output logic [4:0]   eng_mb,
    output logic         eng_ext,
    output logic [28:0]  eng_can_id,
    output logic         eng_rtr,
    output logic [3:0]   eng_dlc,
    output logic [63:0]  eng_payload,
    input  logic         eng_done
);
    localparam int MB_W = $clog2(NUM_MB);

    arb_state_e                   state_q, state_d;
    logic [MB_W-1:0]              cur_mb_q;
    logic [NUM_MB-1:0]            en_q, dir_q, req_q, ack_q, imask_q, cand;
    logic [NUM_MB-1:0][PRIO_W-1:0] prio_vec;
    logic                         pick_any, retire;
    logic [MB_W-1:0]              pick_win;

    can_arb_regs #(.NUM_MB(NUM_MB), .MB_W(MB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .retire(retire), .retire_mb(cur_mb_q), .en_q(en_q), .dir_q(dir_q), .req_q(req_q),
        .ack_q(ack_q), .imask_q(imask_q), .gmif_q(irq_flag)
    );

    can_arb_store #(.NUM_MB(NUM_MB), .MB_W(MB_W), .PRIO_W(PRIO_W), .PRIO_LSB(PRIO_LSB)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_mb(cfg_mb),
        .wr_data(cfg_wdata), .sel_mb(cur_mb_q), .prio_vec(prio_vec), .sel_ext(eng_ext),
        .sel_can_id(eng_can_id), .sel_rtr(eng_rtr), .sel_dlc(eng_dlc), .sel_payload(eng_payload)
    );

    assign cand = req_q & en_q & ~dir_q;

    can_arb_pick #(.NUM_MB(NUM_MB), .MB_W(MB_W), .PRIO_W(PRIO_W)) u_pick (
        .cand(cand), .prio_vec(prio_vec), .any(pick_any), .win(pick_win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_mb_q <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && pick_any) cur_mb_q <= pick_win;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pick_any) state_d = ST_BUSY;
            ST_BUSY:   if (eng_done) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        eng_valid = (state_q == ST_BUSY);
        retire    = (state_q == ST_RETIRE);
        eng_mb    = cur_mb_q;
        pend_mask = req_q;
        ack_mask  = ack_q;
    end

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done) |=> (eng_valid && $stable(eng_mb)))
        else $error("grant changed in flight"); // R10
    AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_valid) |-> $past(cand[pick_win] && (state_q == ST_IDLE)))
        else $error("grant without eligible request"); // R2

    always @(posedge clk) begin
        if (rst_n && pick_any) begin
            for (int j = 0; j < NUM_MB; j++) begin
                if (cand[j]) begin
                    AST_WIN_MAX: assert (prio_vec[j] <= prio_vec[pick_win])
                        else $error("lower priority picked"); // R3
                    AST_WIN_TIE: assert ((prio_vec[j] != prio_vec[pick_win]) || (MB_W'(j) <= pick_win))
                        else $error("tie lost by higher index"); // R4
                end
            end
        end
    end
endmodule

// File: tb/tb_can_tx_mbox_arb.sv
module tb_can_tx_mbox_arb;
    import can_arb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [4:0]  cfg_mb = '0;
    logic [31:0] cfg_wdata = '0;
    logic        eng_done = 1'b0;
    logic [31:0] pend_mask, ack_mask;
    logic        irq_flag, eng_valid, eng_ext, eng_rtr;
    logic [4:0]  eng_mb;
    logic [28:0] eng_can_id;
    logic [3:0]  eng_dlc;
    logic [63:0] eng_payload;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_tx_mbox_arb dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_mb(cfg_mb),
        .cfg_wdata(cfg_wdata), .pend_mask(pend_mask), .ack_mask(ack_mask), .irq_flag(irq_flag),
        .eng_valid(eng_valid), .eng_mb(eng_mb), .eng_ext(eng_ext), .eng_can_id(eng_can_id),
        .eng_rtr(eng_rtr), .eng_dlc(eng_dlc), .eng_payload(eng_payload), .eng_done(eng_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int mb, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_mb = 5'(mb); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_mb(input int mb, input logic [31:0] id, input logic [31:0] ctrl,
                           input logic [31:0] lo, input logic [31:0] hi);
        wr(A_ID, mb, id);
        wr(A_CTRL, mb, ctrl);
        wr(A_DLO, mb, lo);
        wr(A_DHI, mb, hi);
    endtask

    task automatic wait_grant(input string tag, input int mb, input logic ext, input logic [28:0] id,
                              input logic rtr, input logic [3:0] dlc, input logic [63:0] pl);
        for (int n = 0; n < 20 && !eng_valid; n++) @(negedge clk);
        chk({tag, " grant"}, {63'd0, eng_valid}, 64'd1);
        chk({tag, " mailbox"}, {59'd0, eng_mb}, 64'(mb));
        chk("R9 ext flag", {63'd0, eng_ext}, {63'd0, ext});
        chk("R9 identifier", {35'd0, eng_can_id}, {35'd0, id});
        chk("R9 rtr/dlc", {59'd0, eng_rtr, eng_dlc}, {59'd0, rtr, dlc});
        chk("R9 payload", eng_payload, pl);
    endtask

    task automatic finish_frame();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pend", {32'd0, pend_mask}, 64'd0);
        chk("R1 ack", {32'd0, ack_mask}, 64'd0);
        chk("R1 irq/valid", {62'd0, irq_flag, eng_valid}, 64'd0);
    endtask

    task automatic t_priority();
        load_mb(12, 32'h1FFC0000, 32'h2804, 32'hDEADBEEF, 32'h01234567);
        load_mb(7,  32'h8ABCDEF1, 32'h2810, 32'h11111111, 32'h22222222);
        load_mb(3,  32'h048C0000, 32'h0A08, 32'h33333333, 32'h44444444);
        load_mb(20, 32'h00040000, 32'h0502, 32'h00000055, 32'h00000066);
        wr(A_ENABLE, 0, 32'h4010108C);
        wr(A_IMASK, 0, 32'h00000088);
        wr(A_REQSET, 0, 32'h00101088);
        chk("R5 request set", {32'd0, pend_mask}, 64'h00101088);
        wait_grant("R4 tie to higher index", 12, 1'b0, 29'h7FF, 1'b0, 4'd4, 64'h01234567DEADBEEF);
        finish_frame();
        chk("R6 ack after 12", {32'd0, ack_mask}, 64'h00001000);
        chk("R6 request cleared 12", {32'd0, pend_mask}, 64'h00100088);
        chk("R8 masked no flag", {63'd0, irq_flag}, 64'd0);
        wait_grant("R4 tie second", 7, 1'b1, 29'h0ABCDEF1, 1'b1, 4'd0, 64'h2222222211111111);
        finish_frame();
        chk("R8 flag raised", {63'd0, irq_flag}, 64'd1);
        wr(A_FLAG, 0, 32'h00007FFF);
        chk("R8 flag kept without bit 15", {63'd0, irq_flag}, 64'd1);
        wr(A_FLAG, 0, 32'h00008000);
        chk("R8 flag cleared", {63'd0, irq_flag}, 64'd0);
        wait_grant("R3 priority 10", 3, 1'b0, 29'h123, 1'b0, 4'd8, 64'h4444444433333333);
        finish_frame();
        chk("R8 flag raised mb3", {63'd0, irq_flag}, 64'd1);
        wr(A_FLAG, 0, 32'h00008000);
        wait_grant("R3 priority 5", 20, 1'b0, 29'h001, 1'b0, 4'd2, 64'h0000006600000055);
        finish_frame();
        chk("R8 masked mb20", {63'd0, irq_flag}, 64'd0);
        chk("R6 ack all", {32'd0, ack_mask}, 64'h00101088);
        repeat (8) @(negedge clk);
        chk("R6 no resend", {63'd0, eng_valid}, 64'd0);
        chk("R6 no pending", {32'd0, pend_mask}, 64'd0);
    endtask

    task automatic t_ack_clear();
        wr(A_ACKCLR, 0, 32'h00000080);
        chk("R7 clear one bit", {32'd0, ack_mask}, 64'h00101008);
        wr(A_ACKCLR, 0, 32'h00000000);
        chk("R7 zero write", {32'd0, ack_mask}, 64'h00101008);
    endtask

    task automatic t_no_preempt();
        load_mb(2,  32'h00400000, 32'h0101, 32'h1, 32'h2);
        load_mb(30, 32'h9FFFFFFF, 32'h3C08, 32'h3, 32'h4);
        wr(A_REQSET, 0, 32'h00000004);
        wait_grant("R2 low first", 2, 1'b0, 29'h010, 1'b0, 4'd1, 64'h0000000200000001);
        wr(A_REQSET, 0, 32'h40000000);
        repeat (3) @(negedge clk);
        chk("R10 still valid", {63'd0, eng_valid}, 64'd1);
        chk("R10 grant held", {59'd0, eng_mb}, 64'd2);
        wr(A_REQSET, 0, 32'h00000000);
        chk("R5 zero bits", {32'd0, pend_mask}, 64'h40000004);
        finish_frame();
        chk("R6 ack mb2", {32'd0, ack_mask}, 64'h0010100C);
        wait_grant("R3 high after", 30, 1'b1, 29'h1FFFFFFF, 1'b0, 4'd8, 64'h0000000400000003);
        finish_frame();
        chk("R6 ack mb30", {32'd0, ack_mask}, 64'h4010100C);
    endtask

    task automatic t_ignore();
        load_mb(5, 32'h11580000, 32'h3F01, 32'h5, 32'h6);
        load_mb(6, 32'h11580000, 32'h3F03, 32'h7, 32'h8);
        wr(A_DIR, 0, 32'h00000040);
        wr(A_ENABLE, 0, 32'h401010CC);
        wr(A_REQSET, 0, 32'h00000060);
        begin
            logic seen = 1'b0;
            for (int n = 0; n < 10; n++) begin
                @(negedge clk);
                if (eng_valid) seen = 1'b1;
            end
            chk("R2 disabled/receive not granted", {63'd0, seen}, 64'd0);
        end
        chk("R2 requests kept", {32'd0, pend_mask}, 64'h00000060);
        wr(A_DIR, 0, 32'h00000000);
        wait_grant("R2 granted once transmit", 6, 1'b0, 29'h456, 1'b0, 4'd3, 64'h0000000800000007);
        finish_frame();
        chk("R2 disabled still pending", {32'd0, pend_mask}, 64'h00000020);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_ack_clear();
        t_no_preempt();
        t_ignore();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule